// File: doc/BRIEF.md
# Oscillator Tap Controller for a Frequency-Locked Loop

This block is the digital half of a frequency-locked loop. A free-running counter runs on the controlled oscillator's clock. Its value crosses into the reference clock domain as a Gray code. On every reference edge the block takes the difference between two consecutive samples, which gives the number of oscillator cycles in the last reference period. It compares that number with a target multiplier and moves a 10-bit tap word by exactly one step toward the target. The tap word is a 5-bit coarse tap with a 5-bit fine modulation value below it, so a carry out of the fine part moves the coarse tap. The analog oscillator reads the coarse tap, the fine value and a 2-bit band select from the block's outputs.

When the loop is off, the tap word is frozen and software can load it directly through a write strobe. This lets a stored setting be applied without waiting for the loop to settle. When the loop is on, software writes to the tap word are dropped. The target can be rewritten at any time. The write port and the target port are plain strobes with no handshake and no back-pressure, and no data stream passes through the block.

Top module: `fll_tap_ctrl`

## Requirements
- R1: After reset, band_sel is 2, coarse_tap and fine_mod are 0, adjusted is 0, and tap_word reads 16'h8000.
- R2: After reset, the target is 64 oscillator cycles per reference period. A tgt_wr strobe replaces it with tgt_data, and the new target takes effect for later comparisons.
- R3: With the loop enabled and a measured count below the target, the tap value {coarse_tap, fine_mod} rises by exactly one each reference period, and adjusted pulses high for each step.
- R4: With the loop enabled and a measured count above the target, the tap value falls by exactly one each reference period, and adjusted pulses high for each step.
- R5: When the measured count equals the target, the tap value is unchanged and adjusted stays low.
- R6: At the tap value 1023 (coarse 31, fine 31), a count below the target leaves the tap at 1023, with no wrap to 0 and no adjusted pulse.
- R7: At the tap value 0, a count above the target leaves the tap at 0, with no wrap and no adjusted pulse.
- R8: With loop_en low, the tap value and band are held whatever the oscillator does. An sw_wr strobe loads coarse_tap from sw_wdata[12:8], fine_mod from sw_wdata[7:3] and band_sel from sw_wdata[15:14].
- R9: With loop_en high, sw_wr has no effect on the tap value or the band.
- R10: The tap value is one binary number with coarse_tap as its upper 5 bits. A step up from fine 31 gives fine 0 and the next coarse tap.
- R11: In closed loop, with an oscillator whose cycles per reference period rise with the tap value, the tap settles where the count meets the target and then stays there without further adjusted pulses.
- R12: tap_word presents band_sel in bits 15:14, coarse_tap in bits 12:8 and fine_mod in bits 7:3, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; one period is one measurement window |
| osc_clk | input | 1 | Clock from the controlled oscillator |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| loop_en | input | 1 | Loop enable, in the ref_clk domain |
| tgt_wr | input | 1 | Target load strobe |
| tgt_data | input | CNT_W | New target count |
| sw_wr | input | 1 | Software tap load strobe (acted on only while loop_en is low) |
| sw_wdata | input | 16 | Tap load word: band [15:14], coarse [12:8], fine [7:3] |
| tap_word | output | 16 | Current setting in the same layout as sw_wdata |
| coarse_tap | output | 5 | Coarse oscillator tap |
| fine_mod | output | 5 | Fine modulation value |
| band_sel | output | 2 | Oscillator range select |
| adjusted | output | 1 | One ref_clk cycle pulse for each loop step of the tap |

## Verification
The bench drives the oscillator as bursts with an exact number of edges inside each reference period. This makes every measured count known, so the three comparison outcomes can be checked one period at a time. A wrong comparison sense would step the tap the wrong way. An off-by-one comparison would move the tap where the count equals the target. The sweeps cross the fine-to-coarse carry, which a design that steps the two fields separately would get wrong. The sweeps also sit at both ends of the tap range, where a wrapping design would jump between 0 and 1023. Other checks write while the loop runs, which a design that ignores the enable would accept. The closed-loop run uses an oscillator model whose count rises with the tap. It shows that the measurement pipeline overshoots only inside the lock band and then stops stepping.

// File: rtl/fll_pkg.sv
package fll_pkg;
  localparam int COARSE_W = 5;
  localparam int FINE_W   = 5;
  localparam int TAP_W    = COARSE_W + FINE_W;
  localparam int BAND_W   = 2;
  localparam int WORD_W   = 16;
  localparam int COARSE_LSB = 8;
  localparam int FINE_LSB   = 3;
  localparam int BAND_LSB   = 14;
  localparam logic [BAND_W-1:0] BAND_INIT = 2'd2;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/osc_gray_counter.sv
module osc_gray_counter #(
  parameter int W = 10
) (
  input  logic         osc_clk,
  input  logic         rst_n,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] bin_q;
  logic [W-1:0] bin_nxt;

  assign bin_nxt = bin_q + W'(1);

  // Gray value is registered so the crossing sees a clean one-bit change.
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_o <= bin_nxt ^ (bin_nxt >> 1);
    end
  end
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] q_r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= g_stage[s-1].q_r;
      end
    end
  end

  assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] gray_i,
  output logic         valid_o,
  output logic [W-1:0] count_o
);
  logic [W-1:0] bin;
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_comb begin
    bin[W-1] = gray_i[W-1];
    for (int i = W - 2; i >= 0; i--) bin[i] = bin[i+1] ^ gray_i[i];
  end

  // The first enabled edge only takes a baseline; deltas follow from the next.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      valid_o  <= 1'b0;
      count_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (!en) begin
        primed_q <= 1'b0;
      end else begin
        prev_q   <= bin;
        primed_q <= 1'b1;
        if (primed_q) begin
          valid_o <= 1'b1;
          count_o <= bin - prev_q;
        end
      end
    end
  end
endmodule

// File: rtl/tap_stepper.sv
module tap_stepper
  import fll_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int TGT_RESET = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              meas_valid,
  input  logic [CNT_W-1:0]  meas_count,
  input  logic              tgt_wr,
  input  logic [CNT_W-1:0]  tgt_data,
  input  logic              wr_en,
  input  logic [TAP_W-1:0]  wr_tap,
  input  logic [BAND_W-1:0] wr_band,
  output logic [TAP_W-1:0]  tap_o,
  output logic [BAND_W-1:0] band_o,
  output logic              adjusted_o
);
  localparam logic [CNT_W-1:0] TGT_INIT = CNT_W'(TGT_RESET);
  localparam logic [TAP_W-1:0] TAP_ONE  = TAP_W'(1);

  logic [CNT_W-1:0] tgt_q;
  step_e            dir;
  logic             at_top;
  logic             at_bot;

  always_comb begin
    if (meas_count < tgt_q)      dir = STEP_UP;
    else if (meas_count > tgt_q) dir = STEP_DOWN;
    else                         dir = STEP_HOLD;
  end

  assign at_top = &tap_o;
  assign at_bot = (tap_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q      <= TGT_INIT;
      tap_o      <= '0;
      band_o     <= BAND_INIT;
      adjusted_o <= 1'b0;
    end else begin
      adjusted_o <= 1'b0;
      if (tgt_wr) tgt_q <= tgt_data;
      if (!en) begin
        if (wr_en) begin
          tap_o  <= wr_tap;
          band_o <= wr_band;
        end
      end else if (meas_valid) begin
        case (dir)
          STEP_UP: if (!at_top) begin
            tap_o      <= tap_o + TAP_ONE;
            adjusted_o <= 1'b1;
          end
          STEP_DOWN: if (!at_bot) begin
            tap_o      <= tap_o - TAP_ONE;
            adjusted_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fll_tap_ctrl.sv
module fll_tap_ctrl
  import fll_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int TGT_RESET   = 64
) (
  input  logic                ref_clk,
  input  logic                osc_clk,
  input  logic                rst_n,
  input  logic                loop_en,
  input  logic                tgt_wr,
  input  logic [CNT_W-1:0]    tgt_data,
  input  logic                sw_wr,
  input  logic [WORD_W-1:0]   sw_wdata,
  output logic [WORD_W-1:0]   tap_word,
  output logic [COARSE_W-1:0] coarse_tap,
  output logic [FINE_W-1:0]   fine_mod,
  output logic [BAND_W-1:0]   band_sel,
  output logic                adjusted
);
  logic [CNT_W-1:0] gray_osc;
  logic [CNT_W-1:0] gray_ref;
  logic             meas_valid;
  logic [CNT_W-1:0] meas_count;
  logic [TAP_W-1:0] tap;
  logic [TAP_W-1:0] wr_tap;
  logic             unused_wbits;

  assign wr_tap = {sw_wdata[COARSE_LSB +: COARSE_W], sw_wdata[FINE_LSB +: FINE_W]};
  assign unused_wbits = ^{sw_wdata[BAND_LSB-1], sw_wdata[FINE_LSB-1:0]};

  osc_gray_counter #(.W(CNT_W)) u_cnt (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .gray_o  (gray_osc)
  );

  gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (gray_osc),
    .q     (gray_ref)
  );

  period_meter #(.W(CNT_W)) u_meter (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .en      (loop_en),
    .gray_i  (gray_ref),
    .valid_o (meas_valid),
    .count_o (meas_count)
  );

  tap_stepper #(.CNT_W(CNT_W), .TGT_RESET(TGT_RESET)) u_step (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .en         (loop_en),
    .meas_valid (meas_valid),
    .meas_count (meas_count),
    .tgt_wr     (tgt_wr),
    .tgt_data   (tgt_data),
    .wr_en      (sw_wr),
    .wr_tap     (wr_tap),
    .wr_band    (sw_wdata[BAND_LSB +: BAND_W]),
    .tap_o      (tap),
    .band_o     (band_sel),
    .adjusted_o (adjusted)
  );

  assign coarse_tap = tap[TAP_W-1:FINE_W];
  assign fine_mod   = tap[FINE_W-1:0];

  always_comb begin
    tap_word = '0;
    tap_word[COARSE_LSB +: COARSE_W] = coarse_tap;
    tap_word[FINE_LSB +: FINE_W]     = fine_mod;
    tap_word[BAND_LSB +: BAND_W]     = band_sel;
  end
endmodule

// File: rtl/fll_tap_chk.sv
module fll_tap_chk
  import fll_pkg::*;
(
  input logic                ref_clk,
  input logic                rst_n,
  input logic                loop_en,
  input logic                sw_wr,
  input logic [COARSE_W-1:0] coarse_tap,
  input logic [FINE_W-1:0]   fine_mod,
  input logic [BAND_W-1:0]   band_sel,
  input logic                adjusted
);
  localparam logic [TAP_W:0] TAP_MAX = {1'b0, {TAP_W{1'b1}}};
  localparam logic [TAP_W:0] ONE_X   = (TAP_W+1)'(1);

  logic [TAP_W:0] tap_x;
  assign tap_x = {1'b0, coarse_tap, fine_mod};

  AST_STEP_ONE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($past(loop_en) && tap_x != $past(tap_x)) |->
      (tap_x == $past(tap_x) + ONE_X || tap_x == $past(tap_x) - ONE_X)); // R3
  AST_ADJ_MARKS_STEP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    adjusted |-> tap_x != $past(tap_x)); // R4
  AST_NO_WRAP_TOP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($past(loop_en) && $past(tap_x) == TAP_MAX) |-> tap_x != '0); // R6
  AST_NO_WRAP_BOT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($past(loop_en) && $past(tap_x) == '0) |-> tap_x != TAP_MAX); // R7
  AST_HOLD_OFF: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!$past(loop_en) && !$past(sw_wr)) |-> (tap_x == $past(tap_x) && $stable(band_sel))); // R8
  AST_BAND_LOCKED: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(loop_en) |-> $stable(band_sel)); // R9
endmodule

bind fll_tap_ctrl fll_tap_chk u_chk (
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .loop_en    (loop_en),
  .sw_wr      (sw_wr),
  .coarse_tap (coarse_tap),
  .fine_mod   (fine_mod),
  .band_sel   (band_sel),
  .adjusted   (adjusted)
);

// File: tb/sim_fll_tap_ctrl.sv
`timescale 1ns/1ps
module sim_fll_tap_ctrl;
  localparam int REF_PERIOD = 1000;
  localparam int CNT_W = 10;

  logic             ref_clk, osc_clk, rst_n, loop_en, tgt_wr, sw_wr;
  logic [CNT_W-1:0] tgt_data;
  logic [15:0]      sw_wdata, tap_word;
  logic [4:0]       coarse_tap, fine_mod;
  logic [1:0]       band_sel;
  logic             adjusted;

  int  n_tests = 0, n_fail = 0;
  int  osc_n = 0;
  bit  closed_loop = 0;
  bit  done = 0;

  fll_tap_ctrl #(.CNT_W(CNT_W)) u0 (
    .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n), .loop_en(loop_en),
    .tgt_wr(tgt_wr), .tgt_data(tgt_data), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .tap_word(tap_word), .coarse_tap(coarse_tap), .fine_mod(fine_mod),
    .band_sel(band_sel), .adjusted(adjusted)
  );

  function automatic int cur_tap();
    return int'(coarse_tap) * 32 + int'(fine_mod);
  endfunction

  initial begin
    ref_clk = 0;
    forever #(REF_PERIOD/2) ref_clk = ~ref_clk;
  end

  // Oscillator model: a burst of exactly n edges inside each reference period.
  initial begin
    osc_clk = 0;
    forever begin
      @(posedge ref_clk);
      #3;
      begin
        int  n;
        real p;
        n = closed_loop ? (32 + cur_tap() / 16) : osc_n;
        if (n > 0) begin
          p = real'(REF_PERIOD - 20) / real'(n);
          repeat (n) begin
            osc_clk = 1; #(p/2.0);
            osc_clk = 0; #(p/2.0);
          end
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  function automatic logic [15:0] mk_word(int band, int tap);
    logic [15:0] w;
    w = '0;
    w[15:14] = 2'(band);
    w[12:8]  = 5'(tap / 32);
    w[7:3]   = 5'(tap % 32);
    return w;
  endfunction

  task automatic load_tap(int band, int tap);
    sw_wdata = mk_word(band, tap) | 16'h2007;  // don't-care bits set
    sw_wr = 1;
    tick(1);
    sw_wr = 0;
  endtask

  task automatic set_target(int t);
    tgt_data = CNT_W'(t);
    tgt_wr = 1;
    tick(1);
    tgt_wr = 0;
  endtask

  // Run a stepping window and check each period's tap against dir (+1/-1/0).
  task automatic sweep(string req, int dir, int periods);
    int prev;
    prev = cur_tap();
    for (int i = 0; i < periods; i++) begin
      int expv;
      tick(1);
      expv = prev + dir;
      if (expv > 1023) expv = 1023;
      if (expv < 0) expv = 0;
      chk(req, cur_tap(), expv);
      chk({req, " adjusted"}, int'(adjusted), (expv != prev) ? 1 : 0);
      chk("R10 coarse", int'(coarse_tap), expv / 32);
      chk("R10 fine", int'(fine_mod), expv % 32);
      prev = cur_tap();
    end
  endtask

  initial begin
    #(REF_PERIOD * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; loop_en = 0; tgt_wr = 0; sw_wr = 0; tgt_data = '0; sw_wdata = '0;
    tick(3);
    chk("R1 band", int'(band_sel), 2);
    chk("R1 coarse", int'(coarse_tap), 0);
    chk("R1 fine", int'(fine_mod), 0);
    chk("R1 adjusted", int'(adjusted), 0);
    chk("R12 word", int'(tap_word), 16'h8000);
    rst_n = 1;
    tick(2);

    // R8: direct load while disabled, then hold against a running oscillator
    load_tap(1, 17 * 32 + 9);
    chk("R8 coarse", int'(coarse_tap), 17);
    chk("R8 fine", int'(fine_mod), 9);
    chk("R8 band", int'(band_sel), 1);
    chk("R12 word", int'(tap_word), int'(mk_word(1, 17 * 32 + 9)));
    osc_n = 40;
    tick(10);
    chk("R8 hold", cur_tap(), 17 * 32 + 9);
    chk("R8 hold adjusted", int'(adjusted), 0);

    // R3 + R10: slow oscillator, count 50 < 64, crosses fine->coarse carry
    load_tap(2, 118);
    osc_n = 50;
    tick(2);
    loop_en = 1;
    tick(4);
    sweep("R3 up", 1, 14);
    loop_en = 0;
    tick(2);

    // R4: fast oscillator, count 80 > 64, crosses coarse borrow
    load_tap(2, 610);
    osc_n = 80;
    tick(2);
    loop_en = 1;
    tick(4);
    sweep("R4 down", -1, 14);
    loop_en = 0;
    tick(2);

    // R5 + R2 default: count 64 equals reset target
    load_tap(2, 300);
    osc_n = 64;
    tick(2);
    loop_en = 1;
    tick(4);
    sweep("R5 R2 equal", 0, 10);
    // R9: software write while enabled is dropped
    sw_wdata = mk_word(3, 700);
    sw_wr = 1;
    tick(1);
    sw_wr = 0;
    tick(1);
    chk("R9 tap", cur_tap(), 300);
    chk("R9 band", int'(band_sel), 2);
    loop_en = 0;
    tick(2);

    // R2: programmed target 50
    set_target(50);
    load_tap(2, 400);
    osc_n = 50;
    tick(2);
    loop_en = 1;
    tick(4);
    sweep("R2 new target hold", 0, 6);
    osc_n = 49;
    tick(4);
    sweep("R2 new target up", 1, 6);
    loop_en = 0;
    tick(2);
    set_target(64);

    // R6: top saturation
    load_tap(2, 1023);
    osc_n = 40;
    tick(2);
    loop_en = 1;
    tick(4);
    sweep("R6 top", 1, 8);
    chk("R6 stays", cur_tap(), 1023);
    loop_en = 0;
    tick(2);

    // R7: bottom saturation
    load_tap(2, 0);
    osc_n = 100;
    tick(2);
    loop_en = 1;
    tick(4);
    sweep("R7 bottom", -1, 8);
    chk("R7 stays", cur_tap(), 0);
    loop_en = 0;
    tick(2);

    // R11: closed loop; count = 32 + tap/16 meets 64 for taps 512..527
    load_tap(2, 0);
    closed_loop = 1;
    tick(2);
    loop_en = 1;
    tick(700);
    chk_rng("R11 lock", cur_tap(), 512, 527);
    sweep("R11 settled", 0, 20);
    loop_en = 0;
    closed_loop = 0;
    tick(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule